// File: doc/BRIEF.md
# LPC Peripheral I/O and DMA Cycle Responder

This block is the device-side engine of a Low Pin Count bus slave. It watches the frame strobe and the 4-bit multiplexed address/data lines. It recognises the start nibble of I/O and DMA cycles and decodes the cycle type. It collects the address or DMA channel and takes write data. After the host turnaround it takes the bus and drives a fixed number of wait SYNCs for each cycle type. It then drives a ready SYNC, or an error SYNC, and for reads it drives the data byte. It ends every cycle with its own two-clock turnaround.

The register file behind the bus is outside the block. A completed write is handed to it as a one-clock strobe with the address, the data and a DMA flag. A read byte is taken from `rd_data_i`. A slow-device input lets an I/O cycle hold the host in long-wait SYNCs, up to a hard limit. An error input turns the final SYNC into an error SYNC. The DMA request line is a registered copy of an inverted request input. Reset releases the bus and parks that line high.

Top module: `lpc_io_dma_resp`

## Requirements
- R1: One clock after `rst` is sampled high, `lad_oe_o` is 0 and `ldrq_n_o` is 1. Both stay so while `rst` is high, whatever `frame_n_i`, `lad_i` and `dreq_i` do.
- R2: A cycle begins when `frame_n_i` is low with `lad_i` = 0000. The next nibble selects the cycle type: 0000 is an I/O read, 0010 an I/O write, 1000 a DMA read and 1010 a DMA write. Any other value leaves the block idle and undriven.
- R3: An I/O address is four nibbles, most significant first. The block claims the cycle only when address bits [15:3] equal those of `BASE_ADDR`. Otherwise it never drives the bus for that cycle.
- R4: I/O cycles drive wait SYNC 0110: three clocks for a read, two for a write. The first wait clock follows the second clock of the host turnaround.
- R5: A DMA cycle carries a channel nibble whose bits [2:0] must equal `DMA_CH`, then a size nibble that is ignored. It drives wait SYNC 0101: three clocks for a read, four for a write. A different channel leaves the bus undriven.
- R6: After the waits the block drives ready SYNC 0000 for one clock. `rd_data_i` is sampled at the edge that ends the last wait. A read then drives the data low nibble first and the high nibble second. Every cycle ends with one clock of 1111 followed by one clock with the bus released.
- R7: Write data arrives low nibble first. `wr_stb_o` is high for exactly the clock of the final SYNC. During that clock `wr_data_o` holds the byte, `wr_dma_o` holds the cycle kind, and `wr_addr_o` holds the I/O address.
- R8: In an I/O cycle, when `slow_i` is high at the edge ending a wait clock, at or after the fixed count, another wait clock follows. The total never exceeds `LONG_MAX` (330) wait clocks. `slow_i` has no effect on DMA cycles.
- R9: If `err_i` is high at the edge ending the last wait, the final SYNC is 1010 instead of 0000. A read still drives both data nibbles after it.
- R10: `frame_n_i` sampled low during any phase aborts the current cycle, and the bus is released on the next clock. If `lad_i` is 0000 on that edge, a new cycle starts.
- R11: `ldrq_n_o` equals the inverse of `dreq_i` sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n_i | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | Bus nibble as seen at the pins |
| lad_o | output | 4 | Nibble driven by the block |
| lad_oe_o | output | 1 | Output enable for `lad_o` |
| ldrq_n_o | output | 1 | DMA request line, active low |
| dreq_i | input | 1 | DMA request from the device |
| slow_i | input | 1 | Device not ready, extends I/O waits |
| err_i | input | 1 | Report an error SYNC for this cycle |
| rd_data_i | input | 8 | Byte returned on reads |
| wr_stb_o | output | 1 | One-clock strobe of a finished write |
| wr_addr_o | output | 16 | Last received I/O address |
| wr_data_o | output | 8 | Written byte |
| wr_dma_o | output | 1 | Finished write was a DMA cycle |

## Verification
All responses are registered. A host nibble sampled at edge k shows its effect on the outputs in the cycle after edge k. The first wait SYNC therefore pairs with the second turnaround nibble, and the final SYNC pairs with the nibble whose edge ends the last wait. The bench builds, for every transaction, a queue of host nibbles and a parallel queue of expected bus values, strobes and request levels, derived from the per-type wait counts. It drives one queue entry at each falling edge and compares the outputs at the following falling edge, so every expectation lands exactly one register after its stimulus. Extended waits, the 330-clock cap, errors, aborts and mid-cycle reset are placed at fixed offsets inside these queues.

// File: rtl/lpc_resp_pkg.sv
package lpc_resp_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CT, S_ADDR, S_DCH, S_DSZ, S_WDAT,
    S_TARH, S_SYNW, S_SYNF, S_RDAT, S_TARP
  } resp_st_t;

  typedef enum logic [1:0] {K_IO_RD, K_IO_WR, K_DMA_RD, K_DMA_WR} resp_kind_t;

  localparam logic [3:0] NIB_START  = 4'b0000;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;
  localparam logic [3:0] SYNC_ERR   = 4'b1010;
  localparam logic [3:0] NIB_TAR    = 4'b1111;

  function automatic logic kind_is_io(resp_kind_t k);
    return (k == K_IO_RD) || (k == K_IO_WR);
  endfunction

  function automatic logic kind_is_wr(resp_kind_t k);
    return (k == K_IO_WR) || (k == K_DMA_WR);
  endfunction

endpackage

// File: rtl/lpc_nib_shift.sv
module lpc_nib_shift #(
  parameter int W         = 16,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [3:0]   nib,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  generate
    if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (en) q_r <= {q_r[W-5:0], nib};
      end
    end else begin : g_lsb
      always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (en) q_r <= {nib, q_r[W-1:4]};
      end
    end
  endgenerate

  assign q = q_r;
endmodule

// File: rtl/lpc_wait_ctr.sv
module lpc_wait_ctr #(
  parameter int LONG_MAX = 330,
  parameter int CNT_W    = $clog2(LONG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] base,
  input  logic             stretch,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   next_n;

  // next_n is the number of wait clocks finished once this one ends
  assign next_n = {1'b0, cnt_q} + 1'b1;
  assign done   = (next_n >= {1'b0, base}) &&
                  !(stretch && (next_n < (CNT_W+1)'(LONG_MAX)));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpc_io_dma_resp.sv
module lpc_io_dma_resp
  import lpc_resp_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0300,
  parameter int              WIN_BITS    = 3,
  parameter int              DMA_CH_W    = 3,
  parameter logic [DMA_CH_W-1:0] DMA_CH  = 'd2,
  parameter int              WAIT_IO_RD  = 3,
  parameter int              WAIT_IO_WR  = 2,
  parameter int              WAIT_DMA_RD = 3,
  parameter int              WAIT_DMA_WR = 4,
  parameter int              LONG_MAX    = 330
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n_i,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              ldrq_n_o,
  input  logic              dreq_i,
  input  logic              slow_i,
  input  logic              err_i,
  input  logic [7:0]        rd_data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_dma_o
);
  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int NIB_W    = $clog2(ADDR_NIB + 1);
  localparam int CNT_W    = $clog2(LONG_MAX + 1);

  resp_st_t   st_q, st_d;
  resp_kind_t kind_q, kind_d;
  logic [NIB_W-1:0]  nib_q, nib_d;
  logic              addr_en, dat_en, wc_done, enter_fin;
  logic [ADDR_W-1:0] addr_q, full_addr;
  logic [7:0]        rbyte_q;
  logic [CNT_W-1:0]  wbase;
  logic              oe_d;
  logic [3:0]        lad_d;

  lpc_nib_shift #(.W(ADDR_W), .MSB_FIRST(1'b1)) u_addr (
    .clk(clk), .rst(rst), .en(addr_en), .nib(lad_i), .q(addr_q));

  lpc_nib_shift #(.W(8), .MSB_FIRST(1'b0)) u_wdat (
    .clk(clk), .rst(rst), .en(dat_en), .nib(lad_i), .q(wr_data_o));

  always_comb begin
    case (kind_q)
      K_IO_RD:  wbase = CNT_W'(WAIT_IO_RD);
      K_IO_WR:  wbase = CNT_W'(WAIT_IO_WR);
      K_DMA_RD: wbase = CNT_W'(WAIT_DMA_RD);
      default:  wbase = CNT_W'(WAIT_DMA_WR);
    endcase
  end

  lpc_wait_ctr #(.LONG_MAX(LONG_MAX), .CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .clear(st_q != S_SYNW), .step(st_q == S_SYNW),
    .base(wbase), .stretch(kind_is_io(kind_q) && slow_i), .done(wc_done));

  assign full_addr = {addr_q[ADDR_W-5:0], lad_i};

  // cycle sequencer
  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    nib_d   = nib_q;
    addr_en = 1'b0;
    dat_en  = 1'b0;
    if (!frame_n_i) begin
      st_d  = (lad_i == NIB_START) ? S_CT : S_IDLE;
      nib_d = '0;
    end else begin
      case (st_q)
        S_CT: begin
          nib_d = '0;
          case (lad_i)
            4'b0000: begin kind_d = K_IO_RD;  st_d = S_ADDR; end
            4'b0010: begin kind_d = K_IO_WR;  st_d = S_ADDR; end
            4'b1000: begin kind_d = K_DMA_RD; st_d = S_DCH;  end
            4'b1010: begin kind_d = K_DMA_WR; st_d = S_DCH;  end
            default: st_d = S_IDLE;
          endcase
        end
        S_ADDR: begin
          addr_en = 1'b1;
          nib_d   = nib_q + 1'b1;
          if (nib_q == NIB_W'(ADDR_NIB - 1)) begin
            nib_d = '0;
            if (full_addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS])
              st_d = kind_is_wr(kind_q) ? S_WDAT : S_TARH;
            else
              st_d = S_IDLE;
          end
        end
        S_DCH: st_d = (lad_i[DMA_CH_W-1:0] == DMA_CH) ? S_DSZ : S_IDLE;
        S_DSZ: st_d = kind_is_wr(kind_q) ? S_WDAT : S_TARH;
        S_WDAT: begin
          dat_en = 1'b1;
          nib_d  = nib_q + 1'b1;
          if (nib_q == NIB_W'(1)) begin nib_d = '0; st_d = S_TARH; end
        end
        S_TARH: begin
          nib_d = nib_q + 1'b1;
          if (nib_q == NIB_W'(1)) begin nib_d = '0; st_d = S_SYNW; end
        end
        S_SYNW: if (wc_done) st_d = S_SYNF;
        S_SYNF: begin
          nib_d = '0;
          st_d  = kind_is_wr(kind_q) ? S_TARP : S_RDAT;
        end
        S_RDAT: begin
          nib_d = nib_q + 1'b1;
          if (nib_q == NIB_W'(1)) begin nib_d = '0; st_d = S_TARP; end
        end
        S_TARP: begin
          nib_d = nib_q + 1'b1;
          if (nib_q == NIB_W'(1)) begin nib_d = '0; st_d = S_IDLE; end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  assign enter_fin = (st_q == S_SYNW) && (st_d == S_SYNF);

  // next bus value, registered below
  always_comb begin
    oe_d  = 1'b0;
    lad_d = NIB_TAR;
    case (st_d)
      S_SYNW: begin oe_d = 1'b1; lad_d = kind_is_io(kind_d) ? SYNC_LONG : SYNC_SHORT; end
      S_SYNF: begin oe_d = 1'b1; lad_d = err_i ? SYNC_ERR : SYNC_READY; end
      S_RDAT: begin oe_d = 1'b1; lad_d = (nib_d == '0) ? rbyte_q[3:0] : rbyte_q[7:4]; end
      S_TARP: oe_d = (nib_d == '0);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      kind_q   <= K_IO_RD;
      nib_q    <= '0;
      rbyte_q  <= '0;
      lad_o    <= NIB_TAR;
      lad_oe_o <= 1'b0;
      ldrq_n_o <= 1'b1;
      wr_stb_o <= 1'b0;
      wr_dma_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      kind_q   <= kind_d;
      nib_q    <= nib_d;
      lad_o    <= lad_d;
      lad_oe_o <= oe_d;
      ldrq_n_o <= ~dreq_i;
      wr_stb_o <= enter_fin && kind_is_wr(kind_q);
      if (enter_fin) begin
        rbyte_q  <= rd_data_i;
        wr_dma_o <= !kind_is_io(kind_q);
      end
    end
  end

  assign wr_addr_o = addr_q;
endmodule

// File: rtl/lpc_resp_chk.sv
module lpc_resp_chk #(
  parameter int LONG_MAX = 330
) (
  input logic       clk,
  input logic       rst,
  input logic       frame_n_i,
  input logic [3:0] lad_o,
  input logic       lad_oe_o,
  input logic       ldrq_n_o,
  input logic       wr_stb_o
);
  localparam int RUN_W = $clog2(LONG_MAX + 1) + 1;

  logic             rst_seen_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) rst_seen_q <= rst;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (lad_oe_o && lad_o == 4'b0110) begin
      if (run_q != '1) run_q <= run_q + 1'b1;
    end else run_q <= '0;
  end

  // R1
  always @(negedge clk) begin
    if (rst_seen_q === 1'b1)
      reset_release_chk: assert (!lad_oe_o && ldrq_n_o);
  end

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_n_i |=> !lad_oe_o);

  // R7
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);

  // R7
  stb_on_final_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> (lad_oe_o && (lad_o == 4'b0000 || lad_o == 4'b1010)));

  // R8
  long_wait_cap_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_W'(LONG_MAX));
endmodule

bind lpc_io_dma_resp lpc_resp_chk #(.LONG_MAX(LONG_MAX)) u_chk (
  .clk(clk), .rst(rst), .frame_n_i(frame_n_i), .lad_o(lad_o),
  .lad_oe_o(lad_oe_o), .ldrq_n_o(ldrq_n_o), .wr_stb_o(wr_stb_o));

// File: tb/tb_lpc_io_dma_resp.sv
`timescale 1ns/1ps
module tb_lpc_io_dma_resp;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_n = 1'b1;
  logic [3:0] lad_in = 4'hF;
  logic [3:0] lad_out;
  logic       lad_oe, ldrq_n, dreq = 1'b0, slow = 1'b0, err = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic       wstb, wdma;
  logic [15:0] waddr;
  logic [7:0]  wdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] host_q[$];   // {dreq, frame_n, slow, err, lad}
  logic [6:0] exp_q[$];    // {ldrq_n, stb, oe, lad}
  string      tag_q[$];
  logic       cur_dreq = 1'b0;
  logic [15:0] e_addr;
  logic [7:0]  e_data;
  logic        e_dma;

  always #2 clk = ~clk;

  lpc_io_dma_resp dut (
    .clk(clk), .rst(rst), .frame_n_i(frame_n), .lad_i(lad_in), .lad_o(lad_out),
    .lad_oe_o(lad_oe), .ldrq_n_o(ldrq_n), .dreq_i(dreq), .slow_i(slow), .err_i(err),
    .rd_data_i(rdata), .wr_stb_o(wstb), .wr_addr_o(waddr), .wr_data_o(wdata),
    .wr_dma_o(wdma));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void push(input logic fr, input logic sl, input logic er,
      input logic [3:0] l, input logic stb, input logic oe, input logic [3:0] el,
      input string tag);
    host_q.push_back({cur_dreq, fr, sl, er, l});
    exp_q.push_back({~cur_dreq, stb, oe, el});
    tag_q.push_back(tag);
  endfunction

  function automatic void idle(input string tag);
    push(1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, tag);
  endfunction

  // drive at a falling edge, compare at the next falling edge
  task automatic play();
    while (host_q.size() > 0) begin
      logic [7:0] h;
      logic [6:0] e;
      string      t;
      h = host_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      {dreq, frame_n, slow, err, lad_in} = h;
      @(negedge clk);
      chk({t, " oe"}, lad_oe, e[4]);
      if (e[4]) chk({t, " lad"}, lad_out, e[3:0]);
      chk("R11 ldrq", ldrq_n, e[6]);
      chk({t, " R7 stb"}, wstb, e[5]);
      if (e[5]) begin
        chk("R7 wdata", wdata, e_data);
        chk("R7 wdma", wdma, e_dma);
        if (!e_dma) chk("R7 waddr", waddr, e_addr);
      end
    end
  endtask

  // kind: 0 I/O read, 1 I/O write, 2 DMA read, 3 DMA write
  task automatic xfer(input int kind, input logic [15:0] addr, input logic [2:0] ch,
      input logic [7:0] data, input bit hit, input int nw, input bit slow_last,
      input bit er, input string tw, input string tf);
    logic wr, dma;
    logic [3:0] wcode;
    wr = kind[0];
    dma = kind[1];
    wcode = dma ? 4'b0101 : 4'b0110;
    e_addr = addr; e_data = data; e_dma = dma; rdata = data;
    push(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R2");
    push(1'b1, 1'b0, 1'b0, {dma, 1'b0, wr, 1'b0}, 1'b0, 1'b0, 4'h0, "R2");
    if (!dma) begin
      for (int i = 3; i >= 0; i--)
        push(1'b1, 1'b0, 1'b0, addr[i*4 +: 4], 1'b0, 1'b0, 4'h0, "R3");
    end else begin
      push(1'b1, 1'b0, 1'b0, {1'b0, ch}, 1'b0, 1'b0, 4'h0, "R5");
      if (hit) push(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R5");
    end
    if (!hit) begin
      for (int i = 0; i < 8; i++) idle(dma ? "R5" : "R3");
      play();
      return;
    end
    if (wr) begin
      push(1'b1, 1'b0, 1'b0, data[3:0], 1'b0, 1'b0, 4'h0, "R7");
      push(1'b1, 1'b0, 1'b0, data[7:4], 1'b0, 1'b0, 4'h0, "R7");
    end
    idle(tw);
    push(1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, wcode, tw);
    for (int k = 1; k < nw; k++)
      push(1'b1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, wcode, tw);
    push(1'b1, slow_last, er, 4'hF, wr, 1'b1, er ? 4'b1010 : 4'b0000, tf);
    if (!wr) begin
      push(1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, data[3:0], "R6");
      push(1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, data[7:4], "R6");
    end
    push(1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 4'hF, "R6");
    idle("R6");
    idle("R6");
    play();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL all: watchdog got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds the bus released while the host toggles inputs
    frame_n = 1'b0; lad_in = 4'h0; dreq = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", lad_oe, 1'b0);
    chk("R1 ldrq in reset", ldrq_n, 1'b1);
    frame_n = 1'b1; lad_in = 4'hF; dreq = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk("R1 oe after reset", lad_oe, 1'b0);
    chk("R1 stb after reset", wstb, 1'b0);

    // R4/R6 I/O read, R4/R7 I/O write
    xfer(0, 16'h0305, 3'd0, 8'hA5, 1'b1, 3, 1'b0, 1'b0, "R4", "R6");
    xfer(1, 16'h0302, 3'd0, 8'h3C, 1'b1, 2, 1'b0, 1'b0, "R4", "R7");
    // R3 address outside the window
    xfer(0, 16'h0310, 3'd0, 8'h11, 1'b0, 3, 1'b0, 1'b0, "R3", "R3");
    // R2 unsupported cycle type 0100
    push(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R2");
    push(1'b1, 1'b0, 1'b0, 4'b0100, 1'b0, 1'b0, 4'h0, "R2");
    for (int i = 0; i < 12; i++) idle("R2");
    play();
    // R5 DMA read and write, wrong channel
    xfer(2, 16'h0000, 3'd2, 8'h5A, 1'b1, 3, 1'b0, 1'b0, "R5", "R6");
    xfer(3, 16'h0000, 3'd2, 8'hC3, 1'b1, 4, 1'b0, 1'b0, "R5", "R7");
    xfer(2, 16'h0000, 3'd1, 8'h00, 1'b0, 3, 1'b0, 1'b0, "R5", "R5");
    // R8 slow ignored on DMA, extended I/O, capped I/O
    xfer(2, 16'h0000, 3'd2, 8'h69, 1'b1, 3, 1'b1, 1'b0, "R8", "R8");
    xfer(0, 16'h0307, 3'd0, 8'h81, 1'b1, 7, 1'b0, 1'b0, "R8", "R8");
    xfer(1, 16'h0300, 3'd0, 8'h7E, 1'b1, 5, 1'b0, 1'b0, "R8", "R8");
    xfer(0, 16'h0304, 3'd0, 8'h42, 1'b1, 330, 1'b1, 1'b0, "R8", "R8");
    // R9 error on a read and on a DMA write
    xfer(0, 16'h0306, 3'd0, 8'h96, 1'b1, 3, 1'b0, 1'b1, "R4", "R9");
    xfer(3, 16'h0000, 3'd2, 8'hE1, 1'b1, 4, 1'b0, 1'b1, "R5", "R9");

    // R10 abort during the waits, then a clean cycle
    push(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R10");
    push(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R10");
    for (int i = 3; i >= 0; i--)
      push(1'b1, 1'b0, 1'b0, 4'(16'h0301 >> (i*4)), 1'b0, 1'b0, 4'h0, "R10");
    idle("R10");
    push(1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 4'b0110, "R10");
    push(1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0, "R10");
    idle("R10");
    idle("R10");
    play();
    xfer(0, 16'h0303, 3'd0, 8'hD2, 1'b1, 3, 1'b0, 1'b0, "R10", "R10");

    // R11 request line follows dreq one clock later
    cur_dreq = 1'b1;
    repeat (3) idle("R11");
    cur_dreq = 1'b0;
    repeat (2) idle("R11");
    play();

    // R1 reset in the middle of a write cycle
    push(1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R1");
    push(1'b1, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0, 4'h0, "R1");
    for (int i = 0; i < 4; i++) push(1'b1, 1'b0, 1'b0, (i == 1) ? 4'h3 : 4'h0, 1'b0, 1'b0, 4'h0, "R1");
    push(1'b1, 1'b0, 1'b0, 4'h5, 1'b0, 1'b0, 4'h0, "R1");
    push(1'b1, 1'b0, 1'b0, 4'h5, 1'b0, 1'b0, 4'h0, "R1");
    idle("R1");
    push(1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 4'b0110, "R1");
    play();
    rst = 1'b1; dreq = 1'b1;
    @(negedge clk);
    chk("R1 oe mid-cycle reset", lad_oe, 1'b0);
    chk("R1 ldrq mid-cycle reset", ldrq_n, 1'b1);
    chk("R1 stb mid-cycle reset", wstb, 1'b0);
    rst = 1'b0; dreq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 oe after release", lad_oe, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule